// File: doc/BRIEF.md
# Cycle-Steal Byte DMA Controller

This block is a two-channel DMA engine. Each channel moves a single byte for each request it accepts. It takes two bus cycles from the shared memory bus to do so: a read from the channel's source address, then a write of that byte to the channel's destination address. A request comes either from a hardware line that the channel selects or from a software trigger bit written through the register port. After each byte, each address moves on by its own rule, and a transfer counter counts down.

Each channel keeps working source, destination and count registers. A reload latch stands behind each one. When the counter underflows, the count is always restored from its latch. The two addresses are restored only while the global reload-disable bit is clear. Underflow also raises a per-channel flag and the shared interrupt, and it can switch the channel off by itself. Software can copy all three latches back into the working registers at any time. The bus is taken only after an external grant, and channel 0 wins whenever both channels are waiting.

Register map: channel c sits at base `c*16`. Offset 0/1 is source low/high, 2/3 is destination low/high, 4/5 is count low/high, 6 is mode, 7 is hardware select, and 8 is control (write) or status (read). The global register is at address 0x20.

Top module: `cyc_steal_dma`

## Requirements
- R1: An accepted request gives exactly one read cycle (`bus_re`, `bus_addr` = source) and, in the next cycle, one write cycle (`bus_we`, `bus_addr` = destination). The write data equals the `bus_rdata` value returned during the read cycle.
- R2: A request is raised by writing a 1 to control bit 0, or by the hardware line `hw_req[sel]` being high for a cycle. Here `sel` is select-register bits [2:0], and it counts only while select-register bit 7 is 1. Lines that are not selected have no effect.
- R3: After each transfer, the source address follows mode bits [1:0] and the destination address follows mode bits [3:2]. The codes are 00 hold, 01 add one, 10 subtract one, and 11 hold.
- R4: The count decrements on each transfer. A transfer that starts with the count at 0 is an underflow, and it reloads the count from its latch whatever the reload-disable setting.
- R5: On underflow, source and destination reload from their latches when global bit 0 (reload-disable) is 0. When that bit is 1, they keep stepping per R3.
- R6: Underflow sets the channel status bit 0 and the global interrupt flag (global bit 1, driven on `irq`). Writing control bit 2 clears the channel flag. Writing a 1 to global bit 1 clears the interrupt.
- R7: If mode bit 5 is 1, underflow clears the channel enable (mode bit 4), and later triggers produce no transfer.
- R8: Writing a 1 to control bit 1 copies the three latches into the working source, destination and count registers.
- R9: A register-port write to a source, destination or count byte updates both the latch and the working register. Reads return the working value.
- R10: When both channels have a request waiting at grant time, channel 0 is served first.
- R11: A trigger while mode bit 4 is 0 is dropped. It causes no transfer, either then or after the channel is later enabled.
- R12: `bus_req` stays high while a request is waiting or a transfer is running. No bus cycle starts until `bus_gnt` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hw_req | input | NHW (8) | Hardware request lines |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW (16) | Memory address |
| bus_re | output | 1 | Read cycle strobe |
| bus_we | output | 1 | Write cycle strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid during the read cycle |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions check the following on every cycle:
- each read is followed by exactly one write that carries the byte just read;
- no read starts without a prior grant;
- channel 1 never starts while channel 0 is waiting;
- an underflow always raises `irq` on the next cycle.

Other behaviour can only be shown through the bench's scenarios, using a model of the expected register state:
- the address stepping codes;
- reloading on underflow with the disable bit clear and set;
- auto-disable;
- dropping triggers while the channel is disabled;
- the software reload.

// File: rtl/csd_pkg.sv
// Package: shared offsets and FSM state type for the cycle-steal DMA.
// Assumes the channel register window is 16 bytes wide.
package csd_pkg;
    localparam logic [3:0] OFF_SRC_LO = 4'd0;
    localparam logic [3:0] OFF_SRC_HI = 4'd1;
    localparam logic [3:0] OFF_DST_LO = 4'd2;
    localparam logic [3:0] OFF_DST_HI = 4'd3;
    localparam logic [3:0] OFF_CNT_LO = 4'd4;
    localparam logic [3:0] OFF_CNT_HI = 4'd5;
    localparam logic [3:0] OFF_MODE   = 4'd6;
    localparam logic [3:0] OFF_HWSEL  = 4'd7;
    localparam logic [3:0] OFF_CTRL   = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } csd_state_e;
endpackage

// File: rtl/csd_prio_arb.sv
// Fixed-priority picker: the lowest-numbered requester wins.
// Assumes NCH >= 1; it is purely combinational.
module csd_prio_arb #(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] onehot,
    output logic [CHW-1:0] idx
);
    // Scan from the top down so that the lowest index is assigned last.
    always_comb begin
        onehot = '0;
        idx    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/csd_channel.sv
// One DMA channel: working and latch registers, mode, hardware select,
// pending request, underflow flag and post-transfer update.
// Assumes 9 <= AW,CW <= 16 (low byte plus high byte) and NHW <= 128.
module csd_channel
    import csd_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int NHW = 8,
    localparam int SELW = (NHW > 1) ? $clog2(NHW) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     wr_off,
    input  logic [7:0]     wr_data,
    input  logic [3:0]     rd_off,
    output logic [7:0]     rd_data,
    input  logic           reload_dis,
    input  logic [NHW-1:0] hw_req,
    input  logic           start,
    input  logic           done,
    output logic [AW-1:0]  src,
    output logic [AW-1:0]  dst,
    output logic           pend,
    output logic           en,
    output logic           uf_evt
);
    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    logic [AW-1:0]   src_q, dst_q, src_lat, dst_lat;
    logic [CW-1:0]   cnt_q, cnt_lat;
    logic [5:0]      mode_q;
    logic            hw_on_q;
    logic [SELW-1:0] hw_sel_q;
    logic            pend_q, uf_q;
    logic            ctrl_wr, sw_trig, hw_hit;
    logic [AW-1:0]   src_nx, dst_nx;
    logic [15:0]     src16, dst16, cnt16;

    // Move an address by its two-bit update code.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] u);
        case (u)
            2'b01:   return a + A_ONE;
            2'b10:   return a - A_ONE;
            default: return a;
        endcase
    endfunction

    // Decode the request sources and the stepped addresses.
    always_comb begin
        ctrl_wr = wr_en && (wr_off == OFF_CTRL);
        sw_trig = ctrl_wr && wr_data[0];
        hw_hit  = hw_on_q && hw_req[hw_sel_q];
        src_nx  = step(src_q, mode_q[1:0]);
        dst_nx  = step(dst_q, mode_q[3:2]);
    end

    // Register state: transfer update first, then software writes take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; cnt_q <= '0;
            src_lat <= '0; dst_lat <= '0; cnt_lat <= '0;
            mode_q <= '0; hw_on_q <= 1'b0; hw_sel_q <= '0;
            pend_q <= 1'b0; uf_q <= 1'b0;
        end else begin
            if (ctrl_wr && wr_data[2]) uf_q <= 1'b0;
            if (done) begin
                if (cnt_q == '0) begin
                    cnt_q <= cnt_lat;
                    uf_q  <= 1'b1;
                    if (!reload_dis) begin
                        src_q <= src_lat;
                        dst_q <= dst_lat;
                    end else begin
                        src_q <= src_nx;
                        dst_q <= dst_nx;
                    end
                    if (mode_q[5]) mode_q[4] <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - C_ONE;
                    src_q <= src_nx;
                    dst_q <= dst_nx;
                end
            end
            if (!mode_q[4])              pend_q <= 1'b0;
            else if (sw_trig || hw_hit)  pend_q <= 1'b1;
            else if (start)              pend_q <= 1'b0;
            if (ctrl_wr && wr_data[1]) begin
                src_q <= src_lat;
                dst_q <= dst_lat;
                cnt_q <= cnt_lat;
            end
            if (wr_en) begin
                case (wr_off)
                    OFF_SRC_LO: begin src_q[7:0] <= wr_data; src_lat[7:0] <= wr_data; end
                    OFF_SRC_HI: begin src_q[AW-1:8] <= wr_data[AW-9:0]; src_lat[AW-1:8] <= wr_data[AW-9:0]; end
                    OFF_DST_LO: begin dst_q[7:0] <= wr_data; dst_lat[7:0] <= wr_data; end
                    OFF_DST_HI: begin dst_q[AW-1:8] <= wr_data[AW-9:0]; dst_lat[AW-1:8] <= wr_data[AW-9:0]; end
                    OFF_CNT_LO: begin cnt_q[7:0] <= wr_data; cnt_lat[7:0] <= wr_data; end
                    OFF_CNT_HI: begin cnt_q[CW-1:8] <= wr_data[CW-9:0]; cnt_lat[CW-1:8] <= wr_data[CW-9:0]; end
                    OFF_MODE:   mode_q <= wr_data[5:0];
                    OFF_HWSEL:  begin hw_on_q <= wr_data[7]; hw_sel_q <= wr_data[SELW-1:0]; end
                    default: ;
                endcase
            end
        end
    end

    // Read-back multiplexer over the working registers and status.
    always_comb begin
        src16 = 16'(src_q);
        dst16 = 16'(dst_q);
        cnt16 = 16'(cnt_q);
        case (rd_off)
            OFF_SRC_LO: rd_data = src16[7:0];
            OFF_SRC_HI: rd_data = src16[15:8];
            OFF_DST_LO: rd_data = dst16[7:0];
            OFF_DST_HI: rd_data = dst16[15:8];
            OFF_CNT_LO: rd_data = cnt16[7:0];
            OFF_CNT_HI: rd_data = cnt16[15:8];
            OFF_MODE:   rd_data = {2'b00, mode_q};
            OFF_HWSEL:  rd_data = {hw_on_q, 7'(hw_sel_q)};
            OFF_CTRL:   rd_data = {6'b0, pend_q && mode_q[4], uf_q};
            default:    rd_data = 8'h00;
        endcase
    end

    // Outputs toward the engine and the top.
    assign src    = src_q;
    assign dst    = dst_q;
    assign en     = mode_q[4];
    assign pend   = pend_q && mode_q[4];
    assign uf_evt = done && (cnt_q == '0);
endmodule

// File: rtl/csd_engine.sv
// Bus sequencer: waits for grant, then runs a read cycle and a write cycle
// for the chosen channel. Assumes the grant stays high through both cycles.
module csd_engine
    import csd_pkg::*;
#(
    parameter int AW  = 16,
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          elig,
    input  logic [NCH-1:0][AW-1:0]  src_a,
    input  logic [NCH-1:0][AW-1:0]  dst_a,
    input  logic                    bus_gnt,
    input  logic [7:0]              bus_rdata,
    output logic                    bus_req,
    output logic                    bus_re,
    output logic                    bus_we,
    output logic [AW-1:0]           bus_addr,
    output logic [7:0]              bus_wdata,
    output logic [NCH-1:0]          start,
    output logic [NCH-1:0]          done
);
    csd_state_e     state_q;
    logic [CHW-1:0] sel_q, pick_idx;
    logic [NCH-1:0] pick_oh;
    logic [7:0]     data_q;
    logic           go;

    csd_prio_arb #(.NCH(NCH)) u_arb (
        .req    (elig),
        .onehot (pick_oh),
        .idx    (pick_idx)
    );

    assign go = (state_q == ST_IDLE) && bus_gnt && (|elig);

    // State sequence IDLE -> READ -> WRITE, with channel and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (go) begin
                    state_q <= ST_READ;
                    sel_q   <= pick_idx;
                end
                ST_READ: begin
                    data_q  <= bus_rdata;
                    state_q <= ST_WRITE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus strobes, address and per-channel start/done pulses.
    always_comb begin
        bus_req   = (state_q != ST_IDLE) || (|elig);
        bus_re    = (state_q == ST_READ);
        bus_we    = (state_q == ST_WRITE);
        bus_wdata = data_q;
        case (state_q)
            ST_READ:  bus_addr = src_a[sel_q];
            ST_WRITE: bus_addr = dst_a[sel_q];
            default:  bus_addr = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            start[i] = go && pick_oh[i];
            done[i]  = bus_we && (sel_q == CHW'(i));
        end
    end
endmodule

// File: rtl/cyc_steal_dma.sv
// Top level: two channels, the bus engine, the global reload-disable bit
// and the interrupt flag. Address bit 5 selects the global register;
// bit 4 selects the channel.
module cyc_steal_dma #(
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int NHW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [5:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic [NHW-1:0] hw_req,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_re,
    output logic           bus_we,
    output logic [7:0]     bus_wdata,
    input  logic [7:0]     bus_rdata,
    output logic           irq
);
    localparam int NCH = 2;

    logic [NCH-1:0][AW-1:0] ch_src, ch_dst;
    logic [NCH-1:0][7:0]    ch_rd;
    logic [NCH-1:0]         ch_pend, ch_en, uf_evt, eng_start, eng_done;
    logic                   rld_dis_q, irq_q, glob_wr;

    assign glob_wr = reg_we && reg_addr[5] && (reg_addr[4:0] == 5'd0);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        csd_channel #(.AW(AW), .CW(CW), .NHW(NHW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_we && !reg_addr[5] && (reg_addr[4] == 1'(c))),
            .wr_off     (reg_addr[3:0]),
            .wr_data    (reg_wdata),
            .rd_off     (reg_addr[3:0]),
            .rd_data    (ch_rd[c]),
            .reload_dis (rld_dis_q),
            .hw_req     (hw_req),
            .start      (eng_start[c]),
            .done       (eng_done[c]),
            .src        (ch_src[c]),
            .dst        (ch_dst[c]),
            .pend       (ch_pend[c]),
            .en         (ch_en[c]),
            .uf_evt     (uf_evt[c])
        );
    end

    csd_engine #(.AW(AW), .NCH(NCH)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (ch_pend),
        .src_a     (ch_src),
        .dst_a     (ch_dst),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_re    (bus_re),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .start     (eng_start),
        .done      (eng_done)
    );

    // Global register: reload-disable bit, and an interrupt flag where set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_dis_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (glob_wr) rld_dis_q <= reg_wdata[0];
            if (|uf_evt)                        irq_q <= 1'b1;
            else if (glob_wr && reg_wdata[1])   irq_q <= 1'b0;
        end
    end

    // Read-back selection between the global register and the channels.
    assign reg_rdata = reg_addr[5] ? {6'b0, irq_q, rld_dis_q} : ch_rd[reg_addr[4]];
    assign irq       = irq_q;
endmodule

// File: rtl/csd_checker.sv
// Property checker for cyc_steal_dma; attached to the top by bind.
// Assumes the synchronous active-low reset of the top.
module csd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_re,
    input logic       bus_we,
    input logic       bus_gnt,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input logic [1:0] uf_evt,
    input logic [1:0] eng_start,
    input logic [1:0] ch_pend
);
    p_read_then_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> (bus_we && !bus_re));
    p_write_carries_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_wdata == $past(bus_rdata)));
    p_no_cycle_without_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_re) |-> $past(bus_gnt));
    p_ch0_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start[1] |-> !ch_pend[0]);
    p_irq_on_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|uf_evt) |=> irq);
endmodule

bind cyc_steal_dma csd_checker u_csd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_re    (bus_re),
    .bus_we    (bus_we),
    .bus_gnt   (bus_gnt),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .uf_evt    (uf_evt),
    .eng_start (eng_start),
    .ch_pend   (ch_pend)
);

// File: tb/cyc_steal_dma_bench.sv
`timescale 1ns/1ps
module cyc_steal_dma_bench;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic [7:0]  hw_req = '0;
    logic        bus_req, bus_gnt = 1'b1, bus_re, bus_we, irq;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    int ntest = 0, nfail = 0, cyc = 0;

    // Model state for the randomized channel-0 runs.
    logic [15:0] m_src, m_dst, m_cnt, l_src, l_dst, l_cnt;
    logic [5:0]  m_mode;
    bit          m_rld, m_en;

    cyc_steal_dma u_cyc_steal_dma (.*);

    always #2.5 clk = ~clk;

    function automatic logic [7:0] patt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign bus_rdata = patt(bus_addr);

    function automatic logic [15:0] step(input logic [15:0] a, input logic [1:0] u);
        return (u == 2'b01) ? a + 16'd1 : (u == 2'b10) ? a - 16'd1 : a;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nfail++; ntest++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        ntest++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
    endtask

    task automatic cfg(input int ch, input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] n, input logic [7:0] mode, input logic [7:0] hs);
        logic [5:0] b = 6'(ch * 16);
        wr(b + 6'd0, s[7:0]); wr(b + 6'd1, s[15:8]);
        wr(b + 6'd2, d[7:0]); wr(b + 6'd3, d[15:8]);
        wr(b + 6'd4, n[7:0]); wr(b + 6'd5, n[15:8]);
        wr(b + 6'd7, hs);     wr(b + 6'd6, mode);
    endtask

    task automatic trig(input int ch);
        wr(6'(ch * 16 + 8), 8'h01);
    endtask

    task automatic xfer(input int win, output bit seen, output logic [15:0] ra,
                        output logic [15:0] wa, output logic [7:0] wd);
        seen = 1'b0; ra = '0; wa = '0; wd = '0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (bus_re) begin
                ra = bus_addr;
                @(negedge clk);
                wa = bus_addr; wd = bus_wdata; seen = bus_we;
                return;
            end
        end
    endtask

    // Expected post-transfer update; returns 1 on underflow.
    function automatic bit model_step();
        if (m_cnt == 16'd0) begin
            m_cnt = l_cnt;
            if (!m_rld) begin m_src = l_src; m_dst = l_dst; end
            else begin m_src = step(m_src, m_mode[1:0]); m_dst = step(m_dst, m_mode[3:2]); end
            if (m_mode[5]) m_en = 1'b0;
            return 1'b1;
        end
        m_cnt = m_cnt - 16'd1;
        m_src = step(m_src, m_mode[1:0]);
        m_dst = step(m_dst, m_mode[3:2]);
        return 1'b0;
    endfunction

    initial begin
        bit seen, uf;
        logic [15:0] ra, wa;
        logic [7:0] wd, d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R12 reset bus_req", int'(bus_req), 0);
        chk("R6 reset irq", int'(irq), 0);
        rd(6'd6, d); chk("R7 reset mode", d, 0);

        // R9: writes land in the working registers
        cfg(0, 16'h1234, 16'h4321, 16'h0002, 8'h00, 8'h00);
        rd(6'd0, d); chk("R9 src lo", d, 8'h34);
        rd(6'd1, d); chk("R9 src hi", d, 8'h12);

        // R11: a trigger while disabled is dropped
        trig(0);
        xfer(10, seen, ra, wa, wd); chk("R11 no xfer disabled", int'(seen), 0);
        wr(6'd6, 8'h15);
        xfer(10, seen, ra, wa, wd); chk("R11 not retained", int'(seen), 0);

        // R12 and R1: wait for grant, then read then write
        bus_gnt = 1'b0;
        trig(0);
        repeat (4) @(negedge clk);
        chk("R12 req held", int'(bus_req), 1);
        chk("R12 no cycle", int'(bus_re), 0);
        bus_gnt = 1'b1;
        xfer(10, seen, ra, wa, wd);
        chk("R1 seen", int'(seen), 1);
        chk("R1 read addr", ra, 16'h1234);
        chk("R1 write addr", wa, 16'h4321);
        chk("R1 write data", wd, patt(16'h1234));

        // R8: software reload from the latches
        wr(6'd8, 8'h02);
        rd(6'd0, d); chk("R8 src reload", d, 8'h34);
        rd(6'd4, d); chk("R8 cnt reload", d, 8'h02);

        // R10: channel 0 first when both are waiting
        cfg(1, 16'h2000, 16'h3000, 16'h0005, 8'h15, 8'h00);
        bus_gnt = 1'b0;
        trig(1); trig(0);
        bus_gnt = 1'b1;
        xfer(10, seen, ra, wa, wd); chk("R10 first ch0", ra, 16'h1234);
        xfer(10, seen, ra, wa, wd); chk("R10 then ch1", ra, 16'h2000);

        // R4, R5, R6: underflow with address reload
        wr(6'd8, 8'h02);
        for (int t = 0; t < 3; t++) begin
            trig(0); xfer(10, seen, ra, wa, wd);
        end
        chk("R4 third xfer addr", ra, 16'h1236);
        rd(6'd4, d);  chk("R4 count reloaded", d, 8'h02);
        rd(6'd8, d);  chk("R6 channel flag", int'(d[0]), 1);
        chk("R6 irq set", int'(irq), 1);
        trig(0); xfer(10, seen, ra, wa, wd); chk("R5 addr reloaded", ra, 16'h1234);
        wr(6'd8, 8'h04); wr(6'h20, 8'h02);
        chk("R6 irq cleared", int'(irq), 0);
        rd(6'd8, d); chk("R6 flag cleared", int'(d[0]), 0);

        // R5: reload disabled keeps stepping
        wr(6'h20, 8'h01);
        wr(6'd4, 8'h00); wr(6'd0, 8'h34);
        trig(0); xfer(10, seen, ra, wa, wd); chk("R5 underflow xfer", ra, 16'h1234);
        trig(0); xfer(10, seen, ra, wa, wd); chk("R5 no addr reload", ra, 16'h1235);
        rd(6'd4, d); chk("R4 count reload with disable", d, 8'h00);
        wr(6'd8, 8'h04); wr(6'h20, 8'h02);

        // R7: auto-disable on underflow
        wr(6'd6, 8'h35); wr(6'd8, 8'h02);
        trig(0); xfer(10, seen, ra, wa, wd);
        rd(6'd6, d); chk("R7 enable cleared", d, 8'h25);
        trig(0); xfer(10, seen, ra, wa, wd); chk("R7 no xfer after", int'(seen), 0);
        wr(6'd8, 8'h04); wr(6'h20, 8'h02);

        // R2: hardware line selection
        wr(6'd23, 8'h83);
        @(negedge clk); hw_req[2] = 1'b1; @(negedge clk); hw_req = '0;
        xfer(10, seen, ra, wa, wd); chk("R2 unselected line", int'(seen), 0);
        @(negedge clk); hw_req[3] = 1'b1; @(negedge clk); hw_req = '0;
        xfer(10, seen, ra, wa, wd); chk("R2 selected line", ra, 16'h2001);

        // R3: decrement and hold codes
        cfg(1, 16'h2000, 16'h3000, 16'h0009, 8'h12, 8'h00);
        trig(1); xfer(10, seen, ra, wa, wd);
        trig(1); xfer(10, seen, ra, wa, wd);
        chk("R3 src dec", ra, 16'h1FFF);
        chk("R3 dst hold", wa, 16'h3000);

        // Randomized runs on channel 0 against the model (R3, R4, R5, R6, R7)
        for (int r = 0; r < 10; r++) begin
            l_src = 16'($urandom); l_dst = 16'($urandom);
            l_cnt = 16'($urandom_range(0, 3));
            m_mode = {1'($urandom_range(0, 1)), 1'b1, 2'($urandom), 2'($urandom)};
            m_rld = 1'($urandom_range(0, 1));
            m_src = l_src; m_dst = l_dst; m_cnt = l_cnt; m_en = 1'b1;
            wr(6'h20, {6'b0, 1'b1, m_rld});
            cfg(0, l_src, l_dst, l_cnt, {2'b00, m_mode}, 8'h00);
            for (int k = 0; k < int'(l_cnt) + 3; k++) begin
                trig(0);
                xfer(12, seen, ra, wa, wd);
                if (m_en) begin
                    chk("R1 rand seen", int'(seen), 1);
                    chk("R3 rand src", ra, m_src);
                    chk("R3 rand dst", wa, m_dst);
                    chk("R1 rand data", wd, patt(m_src));
                    uf = model_step();
                    rd(6'd8, d); chk("R6 rand flag", int'(d[0]), int'(uf));
                    chk("R6 rand irq", int'(irq), int'(uf));
                    rd(6'd4, d); chk("R4 rand count", d, m_cnt[7:0]);
                    rd(6'd0, d); chk("R5 rand next src", d, m_src[7:0]);
                    if (uf) begin
                        rd(6'd6, d); chk("R7 rand enable", int'(d[4]), int'(m_en));
                        wr(6'd8, 8'h04); wr(6'h20, {6'b0, 1'b1, m_rld});
                    end
                end else begin
                    chk("R7 rand disabled", int'(seen), 0);
                end
            end
        end

        summary();
        $finish;
    end
endmodule